// File: doc/BRIEF.md
# SPI Serial EEPROM Word Reader

This block is a hardware master that fetches 16-bit words from an SPI serial EEPROM. A one-cycle `start` pulse latches a word offset, a word count and the address-width setting. The block then polls the device's status byte until the device reports that it is not busy. After that it sends one read command and streams the requested words out through a valid/ready interface. It uses the device's internal address auto-increment, so only one command is needed for the whole burst.

The serial bus runs in clock mode 0. The master drives the data line while SCK is low and samples the return line at each rising SCK edge. Each SCK phase lasts `HALF_CYC` system clocks. While busy, the block waits `GAP_CYC` clocks between status polls, with chip select high, and adds that wait to a running total. When the total reaches `MAX_WAIT_CYC`, the block stops polling, raises `err` and frees the bus.

The output stream follows normal valid/ready rules. A word is transferred on a cycle where both `rd_valid` and `rd_ready` are high. Once `rd_valid` is raised, it and `rd_data` hold steady until that transfer happens. While a word waits, the serial clock stays parked low, so a slow consumer stalls the bus and no data is lost.

Top module: `spi_eeprom_reader`

## Requirements
- R1: After reset, `spi_cs_n` is 1, and `spi_sck`, `spi_mosi`, `busy`, `err` and `rd_valid` are all 0.
- R2: A `start` pulse is ignored while `busy` is high. A `start` pulse with `word_count` equal to 0 is also ignored: `busy` stays 0 and no bus activity follows.
- R3: Each status poll is one chip-select frame. It carries opcode 0x05, sent MSB first, followed by 8 status bits shifted in. The block polls again while status bit 0 (the last bit received) is 1. Chip select stays high for `GAP_CYC` clocks between polls.
- R4: After each busy poll the block adds `GAP_CYC` to a wait total. Once that total reaches `MAX_WAIT_CYC`, the block makes no further poll and sends no read command. It sets `err` to 1, drops `busy`, and leaves `spi_cs_n` high. So a device that is busy forever gets ceil(`MAX_WAIT_CYC`/`GAP_CYC`) polls. `err` clears on the next accepted start.
- R5: The read command is opcode 0x03. When `cfg_addr16` is 0 and `word_offset` is 128 or more, the opcode is sent as 0x0B instead: bit 3 carries byte-address bit 8.
- R6: The byte address is twice `word_offset`, sent MSB first right after the opcode. When `cfg_addr16` is 1 it is sent as 16 bits. When `cfg_addr16` is 0 only its low 8 bits are sent.
- R7: One read command serves all `word_count` words. The block shifts in 16 bits per word, with no new command between words, and the device's address wraps at the end of its memory.
- R8: Each word is byte-swapped on output. The first byte received goes to `rd_data[7:0]` and the second byte to `rd_data[15:8]`.
- R9: `spi_mosi` changes only while `spi_sck` is low. It is 0 whenever no bits are being shifted, including whenever `spi_cs_n` is high.
- R10: `spi_sck` is low whenever `spi_cs_n` is high. Each SCK high phase and each SCK low phase lasts `HALF_CYC` clocks.
- R11: While `rd_valid` is high and `rd_ready` is low, `rd_valid` stays high, `rd_data` holds, and `spi_sck` stays low.
- R12: `busy` goes high on the clock after an accepted `start`. It stays high until the last word is accepted or until `err` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request pulse |
| cfg_addr16 | input | 1 | 1 selects a 16-bit address field, 0 selects an 8-bit field; latched at start |
| word_offset | input | OFF_W | First word to read; latched at start |
| word_count | input | CNT_W | Number of words to read; latched at start |
| busy | output | 1 | Request in progress |
| err | output | 1 | Status polling timed out; cleared by the next accepted start |
| rd_valid | output | 1 | Output word available |
| rd_ready | input | 1 | Consumer accepts the word |
| rd_data | output | 16 | Byte-swapped word |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
Some rules hold on every cycle, and assertions watch them continuously:
- SCK stays parked low whenever chip select is high or a word is waiting to be taken.
- MOSI holds steady through each SCK high phase and is low when idle.
- A waiting word keeps its value until it is accepted.
- `busy` covers every valid word.
- An error never coexists with `busy`.

Other behaviour only shows up across whole bench scenarios, where a device model decodes the bus:
- the opcode chosen, including the address-bit-8 variant;
- the doubled byte address;
- the number of polls before a timeout;
- address wraparound;
- byte order;
- the guarantee that a start arriving mid-burst leaves no trace.

// File: rtl/eerd_pkg.sv
package eerd_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRE,
    ST_POLL_OP,
    ST_POLL_IN,
    ST_GAP,
    ST_RD_OP,
    ST_RD_ADDR,
    ST_RD_WORD,
    ST_HOLD
  } eerd_state_e;

  localparam logic [7:0] OPC_STATUS = 8'h05;
  localparam logic [7:0] OPC_READ   = 8'h03;
  localparam logic [7:0] OPC_HI_BIT = 8'h08;

endpackage

// File: rtl/eerd_countdown.sv
module eerd_countdown #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         fired
);

  logic [W-1:0] cnt_q;
  logic         run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      fired <= 1'b0;
    end else if (load) begin
      cnt_q <= val;
      run_q <= (val != '0);
      fired <= 1'b0;
    end else if (run_q) begin
      if (cnt_q <= W'(1)) begin
        run_q <= 1'b0;
        fired <= 1'b1;
      end else begin
        cnt_q <= cnt_q - W'(1);
        fired <= 1'b0;
      end
    end else begin
      fired <= 1'b0;
    end
  end

endmodule

// File: rtl/eerd_bit_shifter.sv
module eerd_bit_shifter #(
  parameter int HALF_CYC = 250
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic [4:0]  nbits,
  input  logic [15:0] tx,
  input  logic        miso,
  output logic        sck,
  output logic        mosi,
  output logic        done,
  output logic [15:0] rx
);

  localparam int HW = (HALF_CYC < 2) ? 1 : $clog2(HALF_CYC);
  localparam logic [HW-1:0] RELOAD = HW'(HALF_CYC - 1);

  logic [HW-1:0] tmr_q;
  logic [3:0]    idx_q;
  logic [15:0]   tx_q;
  logic          active_q;
  logic [3:0]    first_idx;

  assign first_idx = 4'(nbits - 5'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr_q    <= '0;
      idx_q    <= '0;
      tx_q     <= '0;
      active_q <= 1'b0;
      sck      <= 1'b0;
      mosi     <= 1'b0;
      done     <= 1'b0;
      rx       <= '0;
    end else begin
      done <= 1'b0;
      if (!active_q) begin
        if (go) begin
          active_q <= 1'b1;
          idx_q    <= first_idx;
          tx_q     <= tx;
          mosi     <= tx[first_idx];
          tmr_q    <= RELOAD;
          sck      <= 1'b0;
          rx       <= '0;
        end
      end else if (tmr_q != '0) begin
        tmr_q <= tmr_q - HW'(1);
      end else if (!sck) begin
        sck   <= 1'b1;
        rx    <= {rx[14:0], miso};
        tmr_q <= RELOAD;
      end else begin
        sck   <= 1'b0;
        tmr_q <= RELOAD;
        if (idx_q == 4'd0) begin
          active_q <= 1'b0;
          done     <= 1'b1;
          mosi     <= 1'b0;
        end else begin
          idx_q <= idx_q - 4'd1;
          mosi  <= tx_q[idx_q - 4'd1];
        end
      end
    end
  end

  // R9: data line holds through a high SCK phase
  a_r9_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));

  // R9: data line rests low when no bits are moving
  a_r9_mosi_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |-> !mosi);

  // R10: clock only rises inside an active shift
  a_r10_sck_only_active: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> active_q);

endmodule

// File: rtl/spi_eeprom_reader.sv
module spi_eeprom_reader
  import eerd_pkg::*;
#(
  parameter int HALF_CYC     = 250,
  parameter int GAP_CYC      = 1250,
  parameter int MAX_WAIT_CYC = 1250000,
  parameter int OFF_W        = 15,
  parameter int CNT_W        = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cfg_addr16,
  input  logic [OFF_W-1:0] word_offset,
  input  logic [CNT_W-1:0] word_count,
  output logic             busy,
  output logic             err,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [15:0]      rd_data,
  output logic             spi_cs_n,
  output logic             spi_sck,
  output logic             spi_mosi,
  input  logic             spi_miso
);

  localparam int TMR_MAX = (HALF_CYC > GAP_CYC) ? HALF_CYC : GAP_CYC;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int ACC_W   = $clog2(MAX_WAIT_CYC + GAP_CYC + 1);
  localparam logic [TMR_W-1:0] T_HALF = TMR_W'(HALF_CYC);
  localparam logic [TMR_W-1:0] T_GAP  = TMR_W'(GAP_CYC);
  localparam logic [ACC_W-1:0] A_GAP  = ACC_W'(GAP_CYC);
  localparam logic [ACC_W-1:0] A_MAX  = ACC_W'(MAX_WAIT_CYC);

  eerd_state_e      st_q;
  logic [OFF_W-1:0] off_q;
  logic [CNT_W-1:0] left_q;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_next;
  logic             wide_q;
  logic             ready_seen_q;
  logic             cs_n_q;

  logic             sh_go_q;
  logic [4:0]       sh_nbits_q;
  logic [15:0]      sh_tx_q;
  logic             sh_done;
  logic [15:0]      sh_rx;

  logic             tmr_load_q;
  logic [TMR_W-1:0] tmr_val_q;
  logic             tmr_fired;

  logic [15:0]      byte_addr;
  logic             hi_bit;
  logic [7:0]       read_opc;

  assign byte_addr = 16'({off_q, 1'b0});
  assign hi_bit    = !wide_q && (off_q >= OFF_W'(128));
  assign read_opc  = hi_bit ? (OPC_READ | OPC_HI_BIT) : OPC_READ;
  assign acc_next  = acc_q + A_GAP;
  assign spi_cs_n  = cs_n_q;

  eerd_bit_shifter #(.HALF_CYC(HALF_CYC)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (sh_go_q),
    .nbits (sh_nbits_q),
    .tx    (sh_tx_q),
    .miso  (spi_miso),
    .sck   (spi_sck),
    .mosi  (spi_mosi),
    .done  (sh_done),
    .rx    (sh_rx)
  );

  eerd_countdown #(.W(TMR_W)) u_wait (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (tmr_load_q),
    .val   (tmr_val_q),
    .fired (tmr_fired)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q         <= ST_IDLE;
      off_q        <= '0;
      left_q       <= '0;
      acc_q        <= '0;
      wide_q       <= 1'b0;
      ready_seen_q <= 1'b0;
      cs_n_q       <= 1'b1;
      busy         <= 1'b0;
      err          <= 1'b0;
      rd_valid     <= 1'b0;
      rd_data      <= '0;
      sh_go_q      <= 1'b0;
      sh_nbits_q   <= '0;
      sh_tx_q      <= '0;
      tmr_load_q   <= 1'b0;
      tmr_val_q    <= '0;
    end else begin
      sh_go_q    <= 1'b0;
      tmr_load_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start && (word_count != '0)) begin
            off_q        <= word_offset;
            left_q       <= word_count;
            wide_q       <= cfg_addr16;
            acc_q        <= '0;
            ready_seen_q <= 1'b0;
            busy         <= 1'b1;
            err          <= 1'b0;
            tmr_load_q   <= 1'b1;
            tmr_val_q    <= T_HALF;
            st_q         <= ST_PRE;
          end
        end
        ST_PRE: begin
          if (tmr_fired) begin
            cs_n_q     <= 1'b0;
            sh_go_q    <= 1'b1;
            sh_nbits_q <= 5'd8;
            if (ready_seen_q) begin
              sh_tx_q <= {8'h00, read_opc};
              st_q    <= ST_RD_OP;
            end else begin
              sh_tx_q <= {8'h00, OPC_STATUS};
              st_q    <= ST_POLL_OP;
            end
          end
        end
        ST_POLL_OP: begin
          if (sh_done) begin
            sh_go_q    <= 1'b1;
            sh_nbits_q <= 5'd8;
            sh_tx_q    <= '0;
            st_q       <= ST_POLL_IN;
          end
        end
        ST_POLL_IN: begin
          if (sh_done) begin
            cs_n_q     <= 1'b1;
            tmr_load_q <= 1'b1;
            if (!sh_rx[0]) begin
              ready_seen_q <= 1'b1;
              tmr_val_q    <= T_HALF;
              st_q         <= ST_PRE;
            end else begin
              tmr_val_q <= T_GAP;
              st_q      <= ST_GAP;
            end
          end
        end
        ST_GAP: begin
          if (tmr_fired) begin
            if (acc_next >= A_MAX) begin
              err  <= 1'b1;
              busy <= 1'b0;
              st_q <= ST_IDLE;
            end else begin
              acc_q      <= acc_next;
              cs_n_q     <= 1'b0;
              sh_go_q    <= 1'b1;
              sh_nbits_q <= 5'd8;
              sh_tx_q    <= {8'h00, OPC_STATUS};
              st_q       <= ST_POLL_OP;
            end
          end
        end
        ST_RD_OP: begin
          if (sh_done) begin
            sh_go_q    <= 1'b1;
            sh_nbits_q <= wide_q ? 5'd16 : 5'd8;
            sh_tx_q    <= wide_q ? byte_addr : {8'h00, byte_addr[7:0]};
            st_q       <= ST_RD_ADDR;
          end
        end
        ST_RD_ADDR: begin
          if (sh_done) begin
            sh_go_q    <= 1'b1;
            sh_nbits_q <= 5'd16;
            sh_tx_q    <= '0;
            st_q       <= ST_RD_WORD;
          end
        end
        ST_RD_WORD: begin
          if (sh_done) begin
            rd_data  <= {sh_rx[7:0], sh_rx[15:8]};
            rd_valid <= 1'b1;
            st_q     <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (rd_ready) begin
            rd_valid <= 1'b0;
            if (left_q == CNT_W'(1)) begin
              cs_n_q <= 1'b1;
              busy   <= 1'b0;
              st_q   <= ST_IDLE;
            end else begin
              left_q     <= left_q - CNT_W'(1);
              sh_go_q    <= 1'b1;
              sh_nbits_q <= 5'd16;
              sh_tx_q    <= '0;
              st_q       <= ST_RD_WORD;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R10: serial clock parked whenever the device is deselected
  a_r10_sck_low_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  // R9: data line low whenever the device is deselected
  a_r9_mosi_low_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_mosi);

  // R11: a waiting word holds until accepted
  a_r11_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  // R11: the bus is stalled while a word waits
  a_r11_sck_parked: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !spi_sck);

  // R12: every offered word lies inside a busy window
  a_r12_valid_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> busy);

  // R4: a timeout is reported only once the request has ended, bus released
  a_r4_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && spi_cs_n));

endmodule

// File: tb/spi_eeprom_reader_tb.sv
module spi_eeprom_reader_tb;

  localparam int HALF = 2;
  localparam int GAP  = 8;
  localparam int MAXW = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        cfg_addr16 = 1'b1;
  logic [14:0] word_offset = '0;
  logic [15:0] word_count = '0;
  logic        busy, err, rd_valid;
  logic        rd_ready = 1'b1;
  logic [15:0] rd_data;
  logic        spi_cs_n, spi_sck, spi_mosi;
  logic        spi_miso = 1'b0;

  always #2 clk = ~clk;

  spi_eeprom_reader #(
    .HALF_CYC(HALF), .GAP_CYC(GAP), .MAX_WAIT_CYC(MAXW), .OFF_W(15), .CNT_W(16)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_addr16(cfg_addr16),
    .word_offset(word_offset), .word_count(word_count), .busy(busy), .err(err),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // ---------------- device model ----------------
  logic [7:0] mem_b [0:511];
  int         sb_bits = 0;
  logic [7:0] sb_op = '0;
  logic [15:0] sb_addr = '0;
  bit         dev16 = 1'b1;
  int         busy_left = 0;
  int         read_cmds = 0;
  int         stat_cmds = 0;
  logic [7:0] last_op = '0;
  logic [15:0] last_addr = '0;

  function automatic int abits();
    return dev16 ? 16 : 8;
  endfunction

  always @(negedge spi_cs_n) begin
    sb_bits  = 0;
    spi_miso = 1'b0;
  end

  always @(posedge spi_cs_n) begin
    if (sb_bits >= 8 && sb_op == 8'h05) begin
      stat_cmds++;
      if (busy_left > 0) busy_left--;
    end
  end

  always @(posedge spi_sck) begin
    if (!spi_cs_n) begin
      if (sb_bits < 8) sb_op = {sb_op[6:0], spi_mosi};
      else if (sb_op != 8'h05 && sb_bits < 8 + abits()) sb_addr = {sb_addr[14:0], spi_mosi};
      sb_bits++;
      if (sb_bits == 8) begin
        sb_addr = '0;
        if (sb_op != 8'h05) begin
          read_cmds++;
          last_op = sb_op;
        end
      end
      if (sb_op != 8'h05 && sb_bits == 8 + abits()) last_addr = sb_addr;
    end
  end

  always @(negedge spi_sck) begin
    int p;
    int base;
    logic [7:0] sbyte;
    if (!spi_cs_n) begin
      if (sb_op == 8'h05 && sb_bits >= 8) begin
        p = sb_bits - 8;
        sbyte = (busy_left > 0) ? 8'h01 : 8'h00;
        spi_miso = sbyte[7 - (p % 8)];
      end else if ((sb_op == 8'h03 || sb_op == 8'h0B) && sb_bits >= 8 + abits()) begin
        p = sb_bits - 8 - abits();
        base = dev16 ? int'(sb_addr) : int'({sb_op[3], sb_addr[7:0]});
        sbyte = mem_b[(base + p / 8) % 512];
        spi_miso = sbyte[7 - (p % 8)];
      end
    end
  end

  // ---------------- scoreboard ----------------
  logic [15:0] exp_q[$];

  task automatic push_exp(input int off, input int n);
    for (int i = 0; i < n; i++) begin
      int b;
      b = (2 * off + 2 * i) % 512;
      exp_q.push_back({mem_b[(b + 1) % 512], mem_b[b]});
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_valid && rd_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7", "unexpected word", int'(rd_data), 0);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check(rd_data == e, "R8", "word value", int'(rd_data), int'(e));
      end
    end
  end

  // back-pressure pattern
  bit bp_mode = 1'b0;
  int bp_cyc = 0;
  initial begin
    forever begin
      @(negedge clk);
      bp_cyc++;
      rd_ready = bp_mode ? ((bp_cyc % 7) < 2) : 1'b1;
    end
  end

  // bus rule watchers (R9, R10)
  int mosi_bad = 0;
  int sck_bad = 0;
  logic prev_sck = 1'b0, prev_mosi = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (spi_sck && prev_sck && (spi_mosi != prev_mosi)) mosi_bad++;
      if (spi_cs_n && spi_sck) sck_bad++;
      if (!rd_ready && rd_valid && spi_sck) sck_bad++;
    end
    prev_sck  = spi_sck;
    prev_mosi = spi_mosi;
  end

  // ---------------- driver ----------------
  task automatic pulse_start(input int off, input int n, input bit w16);
    @(negedge clk);
    start       = 1'b1;
    word_offset = 15'(off);
    word_count  = 16'(n);
    cfg_addr16  = w16;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic do_read(input int off, input int n, input bit w16, input int polls_busy);
    dev16     = w16;
    busy_left = polls_busy;
    read_cmds = 0;
    stat_cmds = 0;
    push_exp(off, n);
    pulse_start(off, n, w16);
    check(busy == 1'b1, "R12", "busy after start", int'(busy), 1);
    wait (!busy);
    @(negedge clk);
    check(exp_q.size() == 0, "R7", "words outstanding", exp_q.size(), 0);
    check(read_cmds == 1, "R7", "read commands", read_cmds, 1);
    check(stat_cmds == polls_busy + 1, "R3", "status polls", stat_cmds, polls_busy + 1);
    check(last_op == ((!w16 && off >= 128) ? 8'h0B : 8'h03), "R5", "read opcode",
          int'(last_op), (!w16 && off >= 128) ? 8'h0B : 8'h03);
    check(last_addr == (w16 ? 16'(2 * off) : 16'((2 * off) & 255)), "R6", "byte address",
          int'(last_addr), w16 ? (2 * off) & 16'hFFFF : (2 * off) & 255);
    check(spi_cs_n == 1'b1 && err == 1'b0, "R12", "released without error",
          int'({spi_cs_n, err}), 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) mem_b[i] = 8'((i * 37 + 11) ^ (i >> 3));
    repeat (5) @(negedge clk);
    // R1: reset state
    check(spi_cs_n == 1'b1, "R1", "cs_n in reset", int'(spi_cs_n), 1);
    check({spi_sck, spi_mosi} == 2'b00, "R1", "sck/mosi in reset", int'({spi_sck, spi_mosi}), 0);
    check({busy, err, rd_valid} == 3'b000, "R1", "busy/err/valid in reset",
          int'({busy, err, rd_valid}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    do_read(5, 4, 1'b1, 0);      // R6 16-bit address, R8 byte order
    do_read(3, 2, 1'b1, 2);      // R3 busy polls
    do_read(130, 3, 1'b0, 0);    // R5 high address bit in opcode
    do_read(10, 2, 1'b0, 0);     // R5 plain opcode, R6 8-bit address
    do_read(254, 4, 1'b1, 0);    // R7 wrap past end of memory
    bp_mode = 1'b1;
    do_read(20, 6, 1'b1, 1);     // R11 back-pressure
    bp_mode = 1'b0;

    // R2: start while busy is ignored
    dev16 = 1'b1; busy_left = 0; read_cmds = 0; stat_cmds = 0;
    push_exp(40, 3);
    pulse_start(40, 3, 1'b1);
    wait (rd_valid);
    pulse_start(100, 5, 1'b1);
    wait (!busy);
    repeat (20) @(negedge clk);
    check(busy == 1'b0, "R2", "no restart from busy start", int'(busy), 0);
    check(read_cmds == 1, "R2", "single read command", read_cmds, 1);
    check(exp_q.size() == 0, "R2", "words outstanding", exp_q.size(), 0);

    // R2: zero count ignored
    read_cmds = 0; stat_cmds = 0;
    pulse_start(7, 0, 1'b1);
    check(busy == 1'b0, "R2", "busy with zero count", int'(busy), 0);
    repeat (20) @(negedge clk);
    check(stat_cmds + read_cmds == 0, "R2", "bus frames with zero count",
          stat_cmds + read_cmds, 0);

    // R4: polling timeout
    busy_left = 1000; read_cmds = 0; stat_cmds = 0;
    pulse_start(9, 2, 1'b1);
    wait (!busy);
    @(negedge clk);
    check(err == 1'b1, "R4", "err after timeout", int'(err), 1);
    check(stat_cmds == (MAXW + GAP - 1) / GAP, "R4", "polls before timeout",
          stat_cmds, (MAXW + GAP - 1) / GAP);
    check(read_cmds == 0, "R4", "no read after timeout", read_cmds, 0);
    check(spi_cs_n == 1'b1, "R4", "bus released", int'(spi_cs_n), 1);
    repeat (10) @(negedge clk);
    check(rd_valid == 1'b0 && exp_q.size() == 0, "R4", "no data after timeout",
          int'(rd_valid), 0);
    do_read(1, 1, 1'b1, 0);      // R4 err clears on next start
    check(err == 1'b0, "R4", "err cleared", int'(err), 0);

    check(mosi_bad == 0, "R9", "mosi moves during sck high", mosi_bad, 0);
    check(sck_bad == 0, "R10", "sck high while deselected or stalled", sck_bad, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule